// File: doc/BRIEF.md
# Reference Drift Keeper

This block holds one 16-bit baseline level per sensing key and lets that baseline creep slowly toward the key's measured signal. Slow environmental change is absorbed this way, while a real touch is not. The creep is slew-limited: a baseline moves by one count at most, and only after the signal has stayed on the same side of it for a programmed number of drift units. A drift unit is ten 16 ms measurement ticks, so 160 ms. Upward creep (toward touch) and downward creep (away from touch) have separate unit counts, and a count of zero turns that direction off.

While any key reports a touch, every baseline is frozen and its partial count is discarded. After the last touch goes away, the freeze lasts a further programmed number of drift units. A calibration sequence runs out of reset and again whenever software writes a nonzero calibration byte. It samples every key on 15 consecutive ticks and loads each baseline with the integer average of those samples. A busy flag is high for the whole sequence. Thresholds built on top of the baselines, and the touch decision itself, sit outside this block.

Top module: `ref_drift_keeper`

## Requirements
- R1: After reset every baseline reads 0 and `cal_busy_o` is 1, because a calibration sequence starts on its own.
- R2: A calibration sequence takes exactly 15 ticks of `tick_i`. `cal_busy_o` stays 1 until the clock edge that samples the 15th tick, and reads 0 from the next cycle on.
- R3: At the end of calibration, each baseline equals floor(sum of that key's 15 sampled signals / 15). The sampled signals are the values of `sig_i` at the ticks. A key held at 65535 yields 65535.
- R4: A pulse on `cal_wr_i` starts calibration only when `cal_data_i` is nonzero and no sequence is running. A zero byte has no effect. A write during a running sequence neither restarts nor lengthens it.
- R5: A drift unit is one `tick_i` out of every 10, counted from reset: ticks number 10, 20, 30 and so on. Baselines change outside calibration only on such a unit tick.
- R6: While a key's signal is above its baseline, the baseline rises by 1 after every `drift_up_units_i` consecutive drift units.
- R7: While a key's signal is below its baseline, the baseline falls by 1 after every `drift_down_units_i` consecutive drift units.
- R8: A setting of 0 in `drift_up_units_i` or `drift_down_units_i` stops drift in that direction. The other direction is unaffected.
- R9: When the signal crosses to the other side of the baseline or equals it, the partial unit count restarts from zero.
- R10: While `any_touch_i` is 1, no baseline changes and all partial counts are cleared.
- R11: After `any_touch_i` falls, drift stays blocked for `hold_units_i` drift units. It counts again from the next unit after those. A hold of 0 gives no extra blocking.
- R12: No baseline changes during calibration except through the final load.
- R13: Outside the calibration load, a baseline never moves by more than one count per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per 16 ms measurement |
| sig_i | input | NUM_KEYS*SIG_W | Measured signal per key, key k at bits [k*SIG_W +: SIG_W] |
| any_touch_i | input | 1 | 1 while one or more keys are in detect |
| drift_up_units_i | input | SET_W | Drift units per upward step, 0 = off |
| drift_down_units_i | input | SET_W | Drift units per downward step, 0 = off |
| hold_units_i | input | SET_W | Drift units of freeze after the last release |
| cal_wr_i | input | 1 | Write strobe of the calibration byte |
| cal_data_i | input | 8 | Calibration byte, nonzero requests calibration |
| ref_o | output | NUM_KEYS*SIG_W | Baseline per key, same packing as sig_i |
| cal_busy_o | output | 1 | 1 while calibration runs |

## Verification
The bench checks unit timing on exact drift-unit boundaries. A prescaler off by one tick, or a hold timer that blocks one unit too few or too many, shifts a step to the wrong unit and fails the table rows. It reverses the signal of one key in the middle of a count, so a design that keeps the stale count steps immediately. It writes a zero calibration byte and writes again during a running sequence. A design that decodes the byte loosely or restarts the sequence then keeps the busy flag up too long. The averaging test feeds ramps and a full-scale key, which exposes a truncated accumulator or a wrong divisor.

// File: rtl/rdk_pkg.sv
package rdk_pkg;
    typedef enum logic [1:0] {
        DIR_IDLE = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } drift_dir_e;
endpackage

// File: rtl/rdk_prescaler.sv
module rdk_prescaler #(
    parameter int TICKS_PER_UNIT = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    output logic unit_o
);
    localparam int CW = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_UNIT - 1);

    typedef struct packed {
        logic [CW-1:0] phase;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        unit_o = tick_i && (st_q.phase == LAST);
        if (tick_i) begin
            st_d.phase = (st_q.phase == LAST) ? '0 : st_q.phase + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/rdk_hold_timer.sv
module rdk_hold_timer #(
    parameter int SET_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             unit_i,
    input  logic             touch_i,
    input  logic [SET_W-1:0] hold_set_i,
    output logic             clear_o
);
    typedef struct packed {
        logic [SET_W-1:0] remain;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        clear_o = (st_q.remain == '0);
        if (touch_i) begin
            st_d.remain = hold_set_i;
        end else if (unit_i && (st_q.remain != '0)) begin
            st_d.remain = st_q.remain - SET_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/rdk_cal_seq.sv
module rdk_cal_seq #(
    parameter int CAL_BURSTS = 15
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic req_i,
    output logic busy_o,
    output logic sample_o,
    output logic done_o
);
    localparam int BW = $clog2(CAL_BURSTS + 1);
    localparam logic [BW-1:0] LAST = BW'(CAL_BURSTS - 1);

    typedef struct packed {
        logic          busy;
        logic [BW-1:0] count;
    } cal_state_t;

    cal_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        busy_o   = st_q.busy;
        sample_o = st_q.busy && tick_i;
        done_o   = sample_o && (st_q.count == LAST);
        if (!st_q.busy) begin
            if (req_i) begin
                st_d.busy  = 1'b1;
                st_d.count = '0;
            end
        end else if (tick_i) begin
            if (st_q.count == LAST) begin
                st_d.busy  = 1'b0;
                st_d.count = '0;
            end else begin
                st_d.count = st_q.count + BW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{busy: 1'b1, count: '0};
        else         st_q <= st_d;
    end
endmodule

// File: rtl/rdk_key_lane.sv
module rdk_key_lane #(
    parameter int SIG_W      = 16,
    parameter int SET_W      = 8,
    parameter int CAL_BURSTS = 15
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SIG_W-1:0] sig_i,
    input  logic             unit_i,
    input  logic             drift_ok_i,
    input  logic [SET_W-1:0] up_set_i,
    input  logic [SET_W-1:0] down_set_i,
    input  logic             sample_i,
    input  logic             done_i,
    output logic [SIG_W-1:0] ref_o
);
    import rdk_pkg::*;

    localparam int ACC_W = SIG_W + $clog2(CAL_BURSTS + 1);

    typedef struct packed {
        logic [SIG_W-1:0] ref_lvl;
        logic [SET_W-1:0] count;
        drift_dir_e       dir;
        logic [ACC_W-1:0] acc;
    } lane_state_t;

    lane_state_t      st_d, st_q;
    logic [ACC_W-1:0] total;
    logic [SET_W-1:0] base;
    logic [SET_W:0]   step;

    always_comb begin
        st_d  = st_q;
        total = st_q.acc + ACC_W'(sig_i);
        base  = '0;
        step  = '0;
        if (done_i) begin
            st_d.ref_lvl = SIG_W'(total / ACC_W'(CAL_BURSTS));
            st_d.acc     = '0;
            st_d.count   = '0;
            st_d.dir     = DIR_IDLE;
        end else begin
            if (sample_i) begin
                st_d.acc = total;
            end
            if (!drift_ok_i) begin
                st_d.count = '0;
                st_d.dir   = DIR_IDLE;
            end else if (unit_i) begin
                if (sig_i > st_q.ref_lvl) begin
                    base     = (st_q.dir == DIR_UP) ? st_q.count : '0;
                    step     = {1'b0, base} + (SET_W+1)'(1);
                    st_d.dir = DIR_UP;
                    if (up_set_i == '0) begin
                        st_d.count = '0;
                    end else if (step >= {1'b0, up_set_i}) begin
                        st_d.ref_lvl = st_q.ref_lvl + SIG_W'(1);
                        st_d.count   = '0;
                    end else begin
                        st_d.count = SET_W'(step);
                    end
                end else if (sig_i < st_q.ref_lvl) begin
                    base     = (st_q.dir == DIR_DOWN) ? st_q.count : '0;
                    step     = {1'b0, base} + (SET_W+1)'(1);
                    st_d.dir = DIR_DOWN;
                    if (down_set_i == '0) begin
                        st_d.count = '0;
                    end else if (step >= {1'b0, down_set_i}) begin
                        st_d.ref_lvl = st_q.ref_lvl - SIG_W'(1);
                        st_d.count   = '0;
                    end else begin
                        st_d.count = SET_W'(step);
                    end
                end else begin
                    st_d.count = '0;
                    st_d.dir   = DIR_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{ref_lvl: '0, count: '0, dir: DIR_IDLE, acc: '0};
        else         st_q <= st_d;
    end

    assign ref_o = st_q.ref_lvl;
endmodule

// File: rtl/ref_drift_keeper.sv
module ref_drift_keeper #(
    parameter int NUM_KEYS       = 4,
    parameter int SIG_W          = 16,
    parameter int SET_W          = 8,
    parameter int TICKS_PER_UNIT = 10,
    parameter int CAL_BURSTS     = 15
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      tick_i,
    input  logic [NUM_KEYS*SIG_W-1:0] sig_i,
    input  logic                      any_touch_i,
    input  logic [SET_W-1:0]          drift_up_units_i,
    input  logic [SET_W-1:0]          drift_down_units_i,
    input  logic [SET_W-1:0]          hold_units_i,
    input  logic                      cal_wr_i,
    input  logic [7:0]                cal_data_i,
    output logic [NUM_KEYS*SIG_W-1:0] ref_o,
    output logic                      cal_busy_o
);
    logic unit_pulse;
    logic hold_clear;
    logic cal_req;
    logic cal_sample;
    logic cal_done;
    logic drift_ok;

    assign cal_req  = cal_wr_i && (cal_data_i != 8'd0);
    assign drift_ok = !cal_busy_o && hold_clear && !any_touch_i;

    rdk_prescaler #(.TICKS_PER_UNIT(TICKS_PER_UNIT)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick_i),
        .unit_o (unit_pulse)
    );

    rdk_hold_timer #(.SET_W(SET_W)) u_hold (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .unit_i     (unit_pulse),
        .touch_i    (any_touch_i),
        .hold_set_i (hold_units_i),
        .clear_o    (hold_clear)
    );

    rdk_cal_seq #(.CAL_BURSTS(CAL_BURSTS)) u_cal (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .req_i    (cal_req),
        .busy_o   (cal_busy_o),
        .sample_o (cal_sample),
        .done_o   (cal_done)
    );

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_lane
        rdk_key_lane #(
            .SIG_W      (SIG_W),
            .SET_W      (SET_W),
            .CAL_BURSTS (CAL_BURSTS)
        ) u_lane (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .sig_i      (sig_i[k*SIG_W +: SIG_W]),
            .unit_i     (unit_pulse),
            .drift_ok_i (drift_ok),
            .up_set_i   (drift_up_units_i),
            .down_set_i (drift_down_units_i),
            .sample_i   (cal_sample),
            .done_i     (cal_done),
            .ref_o      (ref_o[k*SIG_W +: SIG_W])
        );
    end
endmodule

// File: rtl/rdk_checker.sv
module rdk_checker #(
    parameter int NUM_KEYS = 4,
    parameter int SIG_W    = 16
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic                      tick_i,
    input logic [NUM_KEYS*SIG_W-1:0] sig_i,
    input logic                      any_touch_i,
    input logic                      cal_wr_i,
    input logic [7:0]                cal_data_i,
    input logic [NUM_KEYS*SIG_W-1:0] ref_o,
    input logic                      cal_busy_o
);
    assert_cal_ends_on_burst_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cal_busy_o) |-> $past(tick_i));

    assert_cal_start_needs_byte_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cal_busy_o) |-> $past(cal_wr_i && (cal_data_i != 8'd0)));

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        assert_touch_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(any_touch_i) && !$past(cal_busy_o))
            |-> (ref_o[k*SIG_W +: SIG_W] == $past(ref_o[k*SIG_W +: SIG_W])));

        assert_step_limit_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !$past(cal_busy_o)
            |-> ((ref_o[k*SIG_W +: SIG_W] == $past(ref_o[k*SIG_W +: SIG_W])) ||
                 (ref_o[k*SIG_W +: SIG_W] == SIG_W'($past(ref_o[k*SIG_W +: SIG_W]) + SIG_W'(1))) ||
                 (ref_o[k*SIG_W +: SIG_W] == SIG_W'($past(ref_o[k*SIG_W +: SIG_W]) - SIG_W'(1)))));

        assert_move_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!$past(cal_busy_o) && (ref_o[k*SIG_W +: SIG_W] != $past(ref_o[k*SIG_W +: SIG_W])))
            |-> $past(tick_i));

        assert_rise_toward_signal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!$past(cal_busy_o) && (ref_o[k*SIG_W +: SIG_W] > $past(ref_o[k*SIG_W +: SIG_W])))
            |-> ($past(sig_i[k*SIG_W +: SIG_W]) > $past(ref_o[k*SIG_W +: SIG_W])));

        assert_fall_toward_signal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!$past(cal_busy_o) && (ref_o[k*SIG_W +: SIG_W] < $past(ref_o[k*SIG_W +: SIG_W])))
            |-> ($past(sig_i[k*SIG_W +: SIG_W]) < $past(ref_o[k*SIG_W +: SIG_W])));
    end
endmodule

bind ref_drift_keeper rdk_checker #(.NUM_KEYS(NUM_KEYS), .SIG_W(SIG_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .sig_i       (sig_i),
    .any_touch_i (any_touch_i),
    .cal_wr_i    (cal_wr_i),
    .cal_data_i  (cal_data_i),
    .ref_o       (ref_o),
    .cal_busy_o  (cal_busy_o)
);

// File: tb/ref_drift_keeper_tb_top.sv
`timescale 1ns/1ps
module ref_drift_keeper_tb_top;
    localparam int NK   = 4;
    localparam int SW   = 16;
    localparam int UNIT = 10;
    localparam int ROWS = 6;
    // columns: touch, units to run, expected delta key0, expected delta key1
    localparam int TBL [ROWS][4] = '{
        '{0, 2, 0, -1},
        '{0, 1, 1, -1},
        '{1, 5, 1, -1},
        '{0, 4, 1, -1},
        '{0, 2, 1, -2},
        '{0, 1, 2, -2}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              touch = 1'b0;
    logic [7:0]        up_set = 8'd3;
    logic [7:0]        down_set = 8'd2;
    logic [7:0]        hold_set = 8'd0;
    logic              cal_wr = 1'b0;
    logic [7:0]        cal_data = 8'd0;
    logic [SW-1:0]     sig [NK];
    logic [NK*SW-1:0]  sig_flat;
    logic [NK*SW-1:0]  ref_flat;
    logic              busy;

    int errors = 0;
    int checks = 0;
    int tick_total = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int k = 0; k < NK; k++) sig_flat[k*SW +: SW] = sig[k];
    end

    ref_drift_keeper dut_i (
        .clk_i              (clk),
        .rst_ni             (rst_n),
        .tick_i             (tick),
        .sig_i              (sig_flat),
        .any_touch_i        (touch),
        .drift_up_units_i   (up_set),
        .drift_down_units_i (down_set),
        .hold_units_i       (hold_set),
        .cal_wr_i           (cal_wr),
        .cal_data_i         (cal_data),
        .ref_o              (ref_flat),
        .cal_busy_o         (busy)
    );

    function automatic int ref_of(input int k);
        return int'(ref_flat[k*SW +: SW]);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic one_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        repeat (2) @(negedge clk);
        tick_total++;
    endtask

    task automatic run_units(input int n);
        int seen = 0;
        while (seen < n) begin
            if (tick_total % UNIT == UNIT - 1) seen++;
            one_tick();
        end
    endtask

    task automatic write_cal(input logic [7:0] val);
        @(negedge clk); cal_wr = 1'b1; cal_data = val;
        @(negedge clk); cal_wr = 1'b0; cal_data = 8'd0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int b [NK];
        int sum [NK];
        sig[0] = 16'd1000; sig[1] = 16'd2000; sig[2] = 16'd500; sig[3] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 busy after reset", int'(busy), 1);
        for (int k = 0; k < NK; k++) check("R1 baseline after reset", ref_of(k), 0);

        // R2: reset calibration length
        for (int i = 0; i < 14; i++) one_tick();
        check("R2 busy before last burst", int'(busy), 1);
        one_tick();
        check("R2 busy after 15 bursts", int'(busy), 0);
        check("R3 constant key0", ref_of(0), 1000);
        check("R3 constant key1", ref_of(1), 2000);
        check("R3 constant key2", ref_of(2), 500);
        check("R3 full-scale key3", ref_of(3), 65535);

        // R4: zero byte ignored
        write_cal(8'd0);
        @(negedge clk);
        check("R4 zero byte no start", int'(busy), 0);
        check("R4 zero byte baseline", ref_of(0), 1000);

        // R3/R4/R12: averaging sequence with a write in the middle
        write_cal(8'h5A);
        check("R4 nonzero byte starts", int'(busy), 1);
        for (int k = 0; k < NK; k++) sum[k] = 0;
        for (int i = 0; i < 15; i++) begin
            sig[0] = 16'(1000 + 7 * i);
            sig[1] = 16'(2000 - 11 * i);
            sig[2] = 16'(500 + (i % 4) * 3);
            sig[3] = 16'hFFFF;
            for (int k = 0; k < NK; k++) sum[k] += int'(sig[k]);
            one_tick();
            if (i == 6) write_cal(8'h01);
            if (i == 13) begin
                check("R2 busy mid sequence", int'(busy), 1);
                check("R12 key0 frozen in calibration", ref_of(0), 1000);
                check("R12 key1 frozen in calibration", ref_of(1), 2000);
                check("R12 key2 frozen in calibration", ref_of(2), 500);
            end
        end
        check("R4 write during sequence ignored", int'(busy), 0);
        for (int k = 0; k < NK; k++) begin
            check("R3 averaged baseline", ref_of(k), sum[k] / 15);
            b[k] = ref_of(k);
        end

        // R5-R7 R10 R11 R13: table walk
        sig[0] = 16'(b[0] + 100);
        sig[1] = 16'(b[1] - 100);
        sig[2] = 16'(b[2]);
        up_set = 8'd3; down_set = 8'd2; hold_set = 8'd4;
        for (int r = 0; r < ROWS; r++) begin
            touch = TBL[r][0][0];
            run_units(TBL[r][1]);
            check("R5/R6/R10/R11/R13 key0 row", ref_of(0), b[0] + TBL[r][2]);
            check("R5/R7/R10/R11/R13 key1 row", ref_of(1), b[1] + TBL[r][3]);
            check("R9 equal key2 row", ref_of(2), b[2]);
        end

        // R8: upward drift off, downward continues
        up_set = 8'd0;
        run_units(4);
        check("R8 upward disabled key0", ref_of(0), b[0] + 2);
        check("R7 downward still active key1", ref_of(1), b[1] - 4);

        // R9: reversal restarts count
        up_set = 8'd3;
        sig[2] = 16'(b[2] + 5);
        run_units(2);
        check("R6 partial up count key2", ref_of(2), b[2]);
        sig[2] = 16'(b[2] - 5);
        run_units(1);
        check("R9 reversal restarts count", ref_of(2), b[2]);
        run_units(1);
        check("R7 R9 step after restart", ref_of(2), b[2] - 1);

        // R11: zero hold
        hold_set = 8'd0; down_set = 8'd1;
        @(negedge clk); touch = 1'b1;
        repeat (3) @(negedge clk);
        touch = 1'b0;
        run_units(1);
        check("R11 zero hold drifts at once", ref_of(2), b[2] - 2);
        check("R6 full-scale key3 stays", ref_of(3), 65535);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule